// File: doc/BRIEF.md
# Multi-Link Receive Latency Aligner

This block makes a group of serial links look as though they run in lock step. Serial links differ in cable length, transceiver pipeline latency and clock phase. A single global align pulse, tied to the bunch-crossing-zero reference, goes to every transmit and receive endpoint at once. Each transmit lane counts a scheduled launch delay from that pulse. When the count is reached, the lane sends one 8b/10b comma word (K-flag set, byte 0xBC) in place of its payload word. Each receive lane counts from the same pulse until that comma arrives. The difference between the scheduled arrival count and the measured count becomes the delay that this lane adds to its received stream.

The added delay selects a tap of a per-lane delay line. After alignment, every lane delivers the word that was launched a fixed number of word clocks earlier, and that number is the same for all lanes. A global source select can bypass the measured value and apply one fixed, programmed delay to all lanes. One word clock is the adjustment step, so at a link rate that carries several words per bunch crossing the step is a fraction of the bunch-crossing period. Serialisation, line coding and elastic buffering belong to neighbouring logic.

Top module: `link_align_top`

## Requirements
- R1: After reset, `align_done`, `align_err` and `align_timeout` are 0 and every `meas_delay` field is 0. Each `tx_word` lane equals its `tx_payload` lane and `tx_kflag` is 0.
- R2: Let the align pulse be sampled high at the clock edge that ends cycle 0. Each transmit lane then drives `tx_kflag`=1 with byte 0xBC in cycle `launch_delay`+1 only, and it passes its payload with `tx_kflag`=0 in every other cycle.
- R3: On a receive lane, a comma seen in cycle A+1 after the pulse has arrival count A. If A <= `sched_arrival` and `sched_arrival` - A <= DEPTH-1, then from the following cycle on `meas_delay` holds `sched_arrival` - A and `align_done` is 1.
- R4: `rx_aligned` / `rx_aligned_k` equal the lane's `rx_word` / `rx_kflag` delayed by the applied delay in word clocks, where delay 0 is a direct pass-through. With measured delays applied, every lane therefore shows the same total latency from `tx_payload`, equal to `sched_arrival` - `launch_delay`.
- R5: If the comma arrives late (A > `sched_arrival`), `align_err` is set, `align_done` stays 0 and `meas_delay` keeps its previous value.
- R6: If the needed delay is larger than DEPTH-1, `align_err` is set, `align_done` stays 0 and `meas_delay` keeps its previous value.
- R7: If no comma has been seen by the time the arrival count equals `timeout_lim`, `align_timeout` is 1 from cycle `timeout_lim`+2 on, and `align_done` stays 0.
- R8: `align_done`, `align_err` and `align_timeout` hold their values until the next align pulse. That pulse clears all three, starting in cycle 1.
- R9: When `use_fixed`=1, every lane applies `fixed_delay` in place of its measured value, and `meas_delay` is not changed by this selection.
- R10: A received byte 0xBC with `rx_kflag`=0 is payload and is not taken as the comma.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Synchronous active-low reset |
| align_cmd | input | 1 | Global align pulse |
| launch_delay | input | CW | Scheduled launch count for all transmit lanes |
| sched_arrival | input | CW | Scheduled arrival count for all receive lanes |
| timeout_lim | input | CW | Arrival count at which a missing comma is flagged |
| use_fixed | input | 1 | 1: apply fixed_delay, 0: apply measured delay |
| fixed_delay | input | DW | Programmed delay tap |
| tx_payload | input | NLINKS*W | Payload words, one per lane |
| tx_word | output | NLINKS*W | Words towards the serialisers |
| tx_kflag | output | NLINKS | Control-character flag per transmit lane |
| rx_word | input | NLINKS*W | Words from the deserialisers |
| rx_kflag | input | NLINKS | Control-character flag per receive lane |
| rx_aligned | output | NLINKS*W | Delayed receive words |
| rx_aligned_k | output | NLINKS | Delayed control flags |
| meas_delay | output | NLINKS*DW | Latched measured delay per lane |
| align_done | output | NLINKS | Valid delay latched since the last pulse |
| align_err | output | NLINKS | Late comma or delay out of range |
| align_timeout | output | NLINKS | No comma within timeout_lim |

## Verification
The bench builds the block with NLINKS=2, W=8, DEPTH=8 and CW=6. It wraps each transmit lane back to its receiver through a modelled link latency of 0 to 5 words. Both lanes' latencies are swept against two launch delays and every scheduled arrival from 0 to 15. This covers exact fits, zero and maximum taps, late combs and out-of-range delays, including the retained previous delay after an error. Fixed-delay taps 0 to 7, the timeout edge cycle, and a lookalike uncontrolled 0xBC byte are covered on the same small configuration.

// File: rtl/link_align_pkg.sv
// Package: shared constants and types for the multi-link latency aligner.
// Assumes byte-oriented 8b/10b words, where the comma is a K-flagged 0xBC.
package link_align_pkg;
    localparam logic [7:0] COMMA_BYTE = 8'hBC;

    // State of a receive-side arrival measurement
    typedef enum logic {
        MEAS_IDLE  = 1'b0,
        MEAS_ARMED = 1'b1
    } meas_state_t;
endpackage

// File: rtl/align_tx_launch.sv
// Module: align_tx_launch
// Transmit lane. After an align pulse it counts word clocks and, when the
// count equals launch_delay, substitutes a comma word for the payload
// for exactly one cycle.
// Assumes W >= 8 and that align_cmd is a single-cycle pulse.
module align_tx_launch
    import link_align_pkg::*;
#(
    parameter int W  = 8,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          align_cmd,
    input  logic [CW-1:0] launch_delay,
    input  logic [W-1:0]  payload,
    output logic [W-1:0]  word_out,
    output logic          k_out
);
    localparam logic [W-1:0] COMMA_W = W'(COMMA_BYTE);

    logic [CW-1:0] lcnt;
    logic          running;
    logic          fire;

    // Purpose: launch happens when the running count meets the schedule
    assign fire = running && (lcnt == launch_delay);

    // Purpose: count from the align pulse until the comma has been launched
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lcnt    <= '0;
            running <= 1'b0;
        end else if (align_cmd) begin
            lcnt    <= '0;
            running <= 1'b1;
        end else if (fire) begin
            running <= 1'b0;
        end else if (running) begin
            lcnt <= lcnt + 1'b1;
        end
    end

    // Purpose: choose between the payload and the comma
    always_comb begin
        word_out = fire ? COMMA_W : payload;
        k_out    = fire;
    end
endmodule

// File: rtl/align_rx_measure.sv
// Module: align_rx_measure
// Receive lane measurement. After an align pulse it counts word clocks
// until a K-flagged comma arrives. It then latches
// sched_arrival - count as the lane delay, or flags an error when the comma
// is late or the delay does not fit the delay line. A missing comma is
// flagged once the count reaches timeout_lim.
// Assumes DEPTH >= 2 and that align_cmd is a single-cycle pulse.
module align_rx_measure
    import link_align_pkg::*;
#(
    parameter int W     = 8,
    parameter int CW    = 8,
    parameter int DEPTH = 16,
    parameter int DW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          align_cmd,
    input  logic [CW-1:0] sched_arrival,
    input  logic [CW-1:0] timeout_lim,
    input  logic [W-1:0]  rx_word,
    input  logic          rx_k,
    output logic [DW-1:0] meas_delay,
    output logic          done,
    output logic          err,
    output logic          timeout
);
    localparam logic [W-1:0] COMMA_W  = W'(COMMA_BYTE);
    localparam logic [CW:0]  MAX_TAP  = (CW+1)'(DEPTH - 1);

    meas_state_t   state;
    logic [CW-1:0] acnt;
    logic          hit;
    logic          late;
    logic [CW:0]   need;
    logic          too_big;

    // Purpose: detect the comma and judge the delay it implies
    always_comb begin
        hit     = rx_k && (rx_word == COMMA_W);
        late    = acnt > sched_arrival;
        need    = {1'b0, sched_arrival} - {1'b0, acnt};
        too_big = !late && (need > MAX_TAP);
    end

    // Purpose: arrival counter, delay latch and result flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= MEAS_IDLE;
            acnt       <= '0;
            meas_delay <= '0;
            done       <= 1'b0;
            err        <= 1'b0;
            timeout    <= 1'b0;
        end else if (align_cmd) begin
            state   <= MEAS_ARMED;
            acnt    <= '0;
            done    <= 1'b0;
            err     <= 1'b0;
            timeout <= 1'b0;
        end else if (state == MEAS_ARMED) begin
            if (hit) begin
                state <= MEAS_IDLE;
                if (late || too_big) begin
                    err <= 1'b1;
                end else begin
                    meas_delay <= need[DW-1:0];
                    done       <= 1'b1;
                end
            end else if (acnt == timeout_lim) begin
                state   <= MEAS_IDLE;
                timeout <= 1'b1;
            end else begin
                acnt <= acnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/align_delay_line.sv
// Module: align_delay_line
// Tapped delay line for one receive lane. Tap 0 is a direct pass-through.
// Tap k is the input from k cycles earlier. A select beyond the last tap
// uses the last tap.
// Assumes DEPTH >= 2.
module align_delay_line #(
    parameter int DATA_W = 9,
    parameter int DEPTH  = 16,
    parameter int DW     = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] din,
    input  logic [DW-1:0]     sel,
    output logic [DATA_W-1:0] dout
);
    logic [DATA_W-1:0] tapv [DEPTH];

    assign tapv[0] = din;

    // Purpose: one register stage per tap beyond the pass-through
    for (genvar k = 1; k < DEPTH; k++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) tapv[k] <= '0;
            else        tapv[k] <= tapv[k-1];
        end
    end

    // Purpose: pick the tap that the select names
    always_comb begin
        if (int'(sel) < DEPTH) dout = tapv[sel];
        else                   dout = tapv[DEPTH-1];
    end
endmodule

// File: rtl/link_align_top.sv
// Module: link_align_top
// Multi-link latency aligner. For every lane it has a transmit launcher, a
// receive arrival measurement and a tapped receive delay line. The global
// use_fixed select applies either the measured delay of each lane or one
// fixed delay to all lanes.
// Assumes lanes are packed lane 0 in the low bits, and that the delay line
// depth fits the arrival spread to be absorbed.
module link_align_top
    import link_align_pkg::*;
#(
    parameter int NLINKS = 4,
    parameter int W      = 8,
    parameter int DEPTH  = 16,
    parameter int CW     = 8,
    localparam int DW    = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                align_cmd,
    input  logic [CW-1:0]       launch_delay,
    input  logic [CW-1:0]       sched_arrival,
    input  logic [CW-1:0]       timeout_lim,
    input  logic                use_fixed,
    input  logic [DW-1:0]       fixed_delay,
    input  logic [NLINKS*W-1:0] tx_payload,
    output logic [NLINKS*W-1:0] tx_word,
    output logic [NLINKS-1:0]   tx_kflag,
    input  logic [NLINKS*W-1:0] rx_word,
    input  logic [NLINKS-1:0]   rx_kflag,
    output logic [NLINKS*W-1:0] rx_aligned,
    output logic [NLINKS-1:0]   rx_aligned_k,
    output logic [NLINKS*DW-1:0] meas_delay,
    output logic [NLINKS-1:0]   align_done,
    output logic [NLINKS-1:0]   align_err,
    output logic [NLINKS-1:0]   align_timeout
);
    for (genvar i = 0; i < NLINKS; i++) begin : g_lane
        logic [DW-1:0] lane_meas;
        logic [DW-1:0] lane_sel;
        logic [W:0]    lane_out;

        align_tx_launch #(.W(W), .CW(CW)) u_tx (
            .clk          (clk),
            .rst_n        (rst_n),
            .align_cmd    (align_cmd),
            .launch_delay (launch_delay),
            .payload      (tx_payload[i*W +: W]),
            .word_out     (tx_word[i*W +: W]),
            .k_out        (tx_kflag[i])
        );

        align_rx_measure #(.W(W), .CW(CW), .DEPTH(DEPTH), .DW(DW)) u_meas (
            .clk           (clk),
            .rst_n         (rst_n),
            .align_cmd     (align_cmd),
            .sched_arrival (sched_arrival),
            .timeout_lim   (timeout_lim),
            .rx_word       (rx_word[i*W +: W]),
            .rx_k          (rx_kflag[i]),
            .meas_delay    (lane_meas),
            .done          (align_done[i]),
            .err           (align_err[i]),
            .timeout       (align_timeout[i])
        );

        // Purpose: source select between measured and programmed delay
        assign lane_sel = use_fixed ? fixed_delay : lane_meas;

        align_delay_line #(.DATA_W(W+1), .DEPTH(DEPTH), .DW(DW)) u_dly (
            .clk   (clk),
            .rst_n (rst_n),
            .din   ({rx_kflag[i], rx_word[i*W +: W]}),
            .sel   (lane_sel),
            .dout  (lane_out)
        );

        assign rx_aligned[i*W +: W]   = lane_out[W-1:0];
        assign rx_aligned_k[i]        = lane_out[W];
        assign meas_delay[i*DW +: DW] = lane_meas;
    end
endmodule

// File: rtl/link_align_chk.sv
// Module: link_align_chk
// Checker bound to link_align_top. It holds the temporal properties for the
// transmit comma, the result flags and the retained delay.
module link_align_chk
    import link_align_pkg::*;
#(
    parameter int NLINKS = 4,
    parameter int W      = 8,
    parameter int DW     = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 align_cmd,
    input logic [NLINKS*W-1:0]  tx_word,
    input logic [NLINKS-1:0]    tx_kflag,
    input logic [NLINKS*DW-1:0] meas_delay,
    input logic [NLINKS-1:0]    align_done,
    input logic [NLINKS-1:0]    align_err,
    input logic [NLINKS-1:0]    align_timeout
);
    for (genvar i = 0; i < NLINKS; i++) begin : g_chk
        assert_comma_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
            tx_kflag[i] |-> tx_word[i*W +: W] == W'(COMMA_BYTE));

        assert_done_err_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
            !(align_done[i] && align_err[i]));

        assert_err_keeps_delay_R6: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(align_err[i]) |-> $stable(meas_delay[i*DW +: DW]));

        assert_timeout_no_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !(align_timeout[i] && align_done[i]));

        assert_cmd_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
            align_cmd |=> !align_done[i] && !align_err[i] && !align_timeout[i]);

        assert_done_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
            align_done[i] && !align_cmd |=> align_done[i]);
    end
endmodule

bind link_align_top link_align_chk #(.NLINKS(NLINKS), .W(W), .DW(DW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .align_cmd     (align_cmd),
    .tx_word       (tx_word),
    .tx_kflag      (tx_kflag),
    .meas_delay    (meas_delay),
    .align_done    (align_done),
    .align_err     (align_err),
    .align_timeout (align_timeout)
);

// File: tb/tb_link_align_top.sv
// Bench: two lanes looped back through modelled link latencies. The sweep
// covers launch delay, scheduled arrival and per-lane latency, and each
// expectation is worked out from the requirements.
module tb_link_align_top;
    localparam int NL = 2;
    localparam int W  = 8;
    localparam int DP = 8;
    localparam int CW = 6;
    localparam int DW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic align_cmd = 1'b0;
    logic [CW-1:0] launch_delay = '0;
    logic [CW-1:0] sched_arrival = '0;
    logic [CW-1:0] timeout_lim = 6'd40;
    logic use_fixed = 1'b0;
    logic [DW-1:0] fixed_delay = '0;
    logic [NL*W-1:0] tx_payload;
    logic [NL*W-1:0] tx_word;
    logic [NL-1:0]   tx_kflag;
    logic [NL*W-1:0] rx_word;
    logic [NL-1:0]   rx_kflag;
    logic [NL*W-1:0] rx_aligned;
    logic [NL-1:0]   rx_aligned_k;
    logic [NL*DW-1:0] meas_delay;
    logic [NL-1:0]   align_done;
    logic [NL-1:0]   align_err;
    logic [NL-1:0]   align_timeout;

    int checks = 0;
    int errors = 0;
    int lat [NL];
    int exp_d [NL];
    logic kill = 1'b0;
    logic [7:0] pc = 8'd0;
    logic [8:0] pipe [NL][8];

    always #10 clk = ~clk;

    link_align_top #(.NLINKS(NL), .W(W), .DEPTH(DP), .CW(CW)) dut (
        .clk(clk), .rst_n(rst_n), .align_cmd(align_cmd),
        .launch_delay(launch_delay), .sched_arrival(sched_arrival),
        .timeout_lim(timeout_lim), .use_fixed(use_fixed),
        .fixed_delay(fixed_delay), .tx_payload(tx_payload),
        .tx_word(tx_word), .tx_kflag(tx_kflag), .rx_word(rx_word),
        .rx_kflag(rx_kflag), .rx_aligned(rx_aligned),
        .rx_aligned_k(rx_aligned_k), .meas_delay(meas_delay),
        .align_done(align_done), .align_err(align_err),
        .align_timeout(align_timeout)
    );

    // Payload: a free-running count, offset by 16 per lane
    always @(posedge clk) pc <= pc + 8'd1;
    assign tx_payload = {pc + 8'd16, pc};

    // Link model: per-lane latency in words
    always @(posedge clk) begin
        for (int i = 0; i < NL; i++) begin
            pipe[i][0] <= {tx_kflag[i], tx_word[i*W +: W]};
            for (int j = 1; j < 8; j++) pipe[i][j] <= pipe[i][j-1];
        end
    end

    always_comb begin
        for (int i = 0; i < NL; i++) begin
            {rx_kflag[i], rx_word[i*W +: W]} = kill ? 9'h0BC :
                (lat[i] == 0) ? {tx_kflag[i], tx_word[i*W +: W]} : pipe[i][lat[i]-1];
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Pulse the align command; returns in the middle of cycle 1
    task automatic pulse_cmd();
        @(negedge clk) align_cmd = 1'b1;
        @(negedge clk) align_cmd = 1'b0;
    endtask

    // Aligned output of lane i must be the payload from lat+d cycles back
    task automatic chk_stream(input string req, input int i, input int d);
        chk(req, {23'd0, rx_aligned_k[i], rx_aligned[i*W +: W]},
            (pc - lat[i] - d + 16*i) & 8'hFF);
    endtask

    task automatic run_trial(input int l, input int s);
        int txbad;
        txbad = 0;
        launch_delay  = CW'(l);
        sched_arrival = CW'(s);
        pulse_cmd();
        for (int c = 1; c <= 24; c++) begin
            for (int i = 0; i < NL; i++)
                if (tx_kflag[i] != (c == l + 1)) txbad++;
            @(negedge clk);
        end
        chk("R2 launch cycle", txbad, 0);
        for (int i = 0; i < NL; i++) begin
            int a;
            a = l + lat[i];
            if (a > s) begin
                chk("R5 late err", align_err[i], 1);
                chk("R5 late done", align_done[i], 0);
                chk("R5 keep delay", meas_delay[i*DW +: DW], exp_d[i]);
            end else if (s - a > DP - 1) begin
                chk("R6 range err", align_err[i], 1);
                chk("R6 range done", align_done[i], 0);
                chk("R6 keep delay", meas_delay[i*DW +: DW], exp_d[i]);
            end else begin
                exp_d[i] = s - a;
                chk("R3 done", align_done[i], 1);
                chk("R3 err", align_err[i], 0);
                chk("R3 delay", meas_delay[i*DW +: DW], exp_d[i]);
            end
            chk("R7 no timeout", align_timeout[i], 0);
            chk_stream("R4 stream", i, exp_d[i]);
        end
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        lat[0] = 0; lat[1] = 0;
        exp_d[0] = 0; exp_d[1] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 done", align_done, 0);
        chk("R1 err", align_err, 0);
        chk("R1 timeout", align_timeout, 0);
        chk("R1 meas", meas_delay, 0);
        chk("R1 tx k", tx_kflag, 0);
        chk("R1 tx pass", tx_word, tx_payload);

        // R2..R6 sweep
        for (int l = 0; l <= 3; l += 3)
            for (int s = 0; s <= 15; s++)
                for (int a0 = 0; a0 <= 5; a0++)
                    for (int a1 = 0; a1 <= 5; a1++) begin
                        lat[0] = a0; lat[1] = a1;
                        run_trial(l, s);
                    end

        // Known good alignment for the hold and fixed tests
        lat[0] = 1; lat[1] = 4;
        run_trial(2, 9);
        chk("R4 lockstep", (rx_aligned[7:0] + 8'd16) & 8'hFF, rx_aligned[15:8]);

        // R8 done held
        repeat (60) @(negedge clk);
        chk("R8 done held", align_done, 2'b11);

        // R9 fixed delay taps
        use_fixed = 1'b1;
        for (int f = 0; f < DP; f++) begin
            fixed_delay = DW'(f);
            repeat (10) @(negedge clk);
            for (int i = 0; i < NL; i++) begin
                chk_stream("R9 fixed stream", i, f);
                chk("R9 meas unchanged", meas_delay[i*DW +: DW], exp_d[i]);
            end
        end
        use_fixed = 1'b0;

        // R7 timeout with R10 lookalike byte, R8 clear on pulse
        kill = 1'b1;
        timeout_lim = 6'd10;
        pulse_cmd();
        chk("R8 done cleared", align_done, 0);
        repeat (10) @(negedge clk);
        chk("R7 before limit", align_timeout, 0);
        @(negedge clk);
        chk("R7 timeout set", align_timeout, 2'b11);
        chk("R10 no false comma", align_done, 0);
        chk("R10 meas kept", meas_delay, {3'(exp_d[1]), 3'(exp_d[0])});
        kill = 1'b0;
        pulse_cmd();
        chk("R8 timeout cleared", align_timeout, 0);
        repeat (30) @(negedge clk);
        chk("R3 realign done", align_done, 2'b11);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule